// File: doc/BRIEF.md
# Speculative Load Address Table

A load that the compiler moves above an earlier store may read stale data if the store writes the same word. This block keeps a small associative record of such hoisted loads. When a speculative load issues, the pipeline inserts the load's destination register tag and its word address. Every store that executes afterwards presents its address on a snoop port. Any recorded entry with that exact address loses its valid bit.

At the load's original program position, a check operation looks up the register tag. The block answers one cycle later. If a valid entry holds that tag, the speculative value is safe. If no valid entry holds it, the pipeline must send the load through its recovery path and re-execute it. That outcome covers a store conflict, an eviction and a flush alike. Performing the reload is the caller's job.

The table holds a fixed number of entries, with at most one entry per register tag. Once every entry is in use, new tags replace old entries in round-robin order. A flush empties the table in one cycle.

Top module: `sld_table`

## Requirements
- R1: After a synchronous active-high reset, no entry is valid. `rsp_valid`, `rsp_hit` and `rsp_reexec` are all low, and a later check of any tag reports re-execute.
- R2: A check answers with `rsp_valid` high in the cycle after `chk_valid`. It reports `rsp_hit`=1 and `rsp_reexec`=0 exactly when a valid entry holds `chk_tag`, and `rsp_hit`=0 and `rsp_reexec`=1 otherwise.
- R3: A snoop invalidates every valid entry whose stored address equals `snp_addr` in all ADDR_W bits. Entries whose address differs in any bit, even a single bit, keep their state.
- R4: Inserting a tag that a valid entry already holds overwrites that entry's address and allocates no second entry. A later snoop of the old address therefore leaves the tag valid.
- R5: An insert of a new tag takes the lowest-index invalid entry. When all entries are valid, it evicts the entry at a round-robin pointer instead. The pointer starts at entry 0 and advances by one per eviction, wrapping at ENTRIES-1. A check of an evicted tag reports re-execute.
- R6: When an insert and a snoop occur in the same cycle with equal addresses, the snoop wins. The inserted entry ends invalid.
- R7: `flush` invalidates every entry in one cycle, drops any insert in the same cycle, and returns the round-robin pointer to entry 0.
- R8: A check sees the table as it stood at the start of its cycle. An insert, snoop or flush in the same cycle does not affect that answer. `rsp_hit` and `rsp_reexec` are never high together and never high without `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Speculative load issues this cycle |
| ins_tag | input | TAG_W | Destination register tag of the speculative load |
| ins_addr | input | ADDR_W | Word address of the speculative load |
| snp_valid | input | 1 | A store executes this cycle |
| snp_addr | input | ADDR_W | Word address written by the store |
| chk_valid | input | 1 | Check operation this cycle |
| chk_tag | input | TAG_W | Register tag being checked |
| flush | input | 1 | Invalidate the whole table |
| rsp_valid | output | 1 | Check response valid (registered) |
| rsp_hit | output | 1 | Speculative value is safe to use |
| rsp_reexec | output | 1 | Load must be re-executed |

## Verification
Corrupt table state shows at the ports only through a later check, one cycle after that check is issued. A valid bit that is wrongly set lets a stale load pass as a hit. A valid bit that is wrongly cleared turns a safe load into a spurious re-execute. The bench therefore follows every insert, snoop, eviction and flush with checks of both the affected tag and an unaffected tag. A wrong round-robin pointer shows as the wrong tag missing after the table fills. A snoop comparison that ignores some address bits shows as a single-bit-different store that still forces a re-execute.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int DEF_ENTRIES = 8;
  localparam int DEF_TAG_W   = 6;
  localparam int DEF_ADDR_W  = 30;

  typedef enum logic [1:0] {
    SRC_REPLACE = 2'd0,
    SRC_FREE    = 2'd1,
    SRC_EVICT   = 2'd2
  } alloc_src_e;
endpackage

// File: rtl/sld_match.sv
module sld_match #(
  parameter int N      = 8,
  parameter int TAG_W  = 6,
  parameter int ADDR_W = 30
) (
  input  logic [N-1:0]             live,
  input  logic [N-1:0][TAG_W-1:0]  tags,
  input  logic [N-1:0][ADDR_W-1:0] addrs,
  input  logic [TAG_W-1:0]         ins_tag,
  input  logic [TAG_W-1:0]         chk_tag,
  input  logic [ADDR_W-1:0]        snp_addr,
  output logic [N-1:0]             ins_tag_hit,
  output logic [N-1:0]             chk_tag_hit,
  output logic [N-1:0]             snp_addr_hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign ins_tag_hit[g]  = live[g] && (tags[g] == ins_tag);
    assign chk_tag_hit[g]  = live[g] && (tags[g] == chk_tag);
    assign snp_addr_hit[g] = live[g] && (addrs[g] == snp_addr);
  end
endmodule

// File: rtl/sld_alloc.sv
module sld_alloc
  import sld_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          ins_fire,
  input  logic [N-1:0]  live,
  input  logic [N-1:0]  tag_hit,
  output logic [IW-1:0] slot,
  output alloc_src_e    src
);
  logic [IW-1:0] rr_ptr;
  logic [IW-1:0] hit_idx;
  logic [IW-1:0] free_idx;
  logic          any_hit;
  logic          any_free;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    any_hit  = 1'b0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (tag_hit[i]) begin
        hit_idx = IW'(i);
        any_hit = 1'b1;
      end
      if (!live[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    if (any_hit) begin
      slot = hit_idx;
      src  = SRC_REPLACE;
    end else if (any_free) begin
      slot = free_idx;
      src  = SRC_FREE;
    end else begin
      slot = rr_ptr;
      src  = SRC_EVICT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rr_ptr <= '0;
    end else if (ins_fire && src == SRC_EVICT) begin
      rr_ptr <= (rr_ptr == IW'(N - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/sld_table.sv
module sld_table
  import sld_pkg::*;
#(
  parameter int ENTRIES = DEF_ENTRIES,
  parameter int TAG_W   = DEF_TAG_W,
  parameter int ADDR_W  = DEF_ADDR_W,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [TAG_W-1:0]  ins_tag,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  input  logic              flush,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_reexec
);
  logic [ENTRIES-1:0]             ent_live;
  logic [ENTRIES-1:0]             live_nxt;
  logic [ENTRIES-1:0][TAG_W-1:0]  ent_tag;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
  logic [ENTRIES-1:0]             ins_tag_hit;
  logic [ENTRIES-1:0]             chk_tag_hit;
  logic [ENTRIES-1:0]             snp_addr_hit;
  logic [IW-1:0]                  slot;
  alloc_src_e                     src;
  logic                           ins_fire;
  logic                           ins_killed;

  assign ins_fire   = ins_valid && !flush;
  assign ins_killed = snp_valid && (snp_addr == ins_addr);

  sld_match #(
    .N(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
  ) u_match (
    .live(ent_live), .tags(ent_tag), .addrs(ent_addr),
    .ins_tag(ins_tag), .chk_tag(chk_tag), .snp_addr(snp_addr),
    .ins_tag_hit(ins_tag_hit), .chk_tag_hit(chk_tag_hit),
    .snp_addr_hit(snp_addr_hit)
  );

  sld_alloc #(.N(ENTRIES)) u_alloc (
    .clk(clk), .rst(rst), .flush(flush), .ins_fire(ins_fire),
    .live(ent_live), .tag_hit(ins_tag_hit), .slot(slot), .src(src)
  );

  always_comb begin
    live_nxt = ent_live & ~(snp_valid ? snp_addr_hit : '0);
    if (ins_fire) live_nxt[slot] = !ins_killed;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) ent_live <= '0;
    else              ent_live <= live_nxt;
  end

  always_ff @(posedge clk) begin
    if (ins_fire) begin
      ent_tag[slot]  <= ins_tag;
      ent_addr[slot] <= ins_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_reexec <= 1'b0;
    end else begin
      rsp_valid  <= chk_valid;
      rsp_hit    <= chk_valid && (|chk_tag_hit);
      rsp_reexec <= chk_valid && !(|chk_tag_hit);
    end
  end
endmodule

// File: rtl/sld_table_chk.sv
module sld_table_chk #(
  parameter int TAG_W  = 6,
  parameter int ADDR_W = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              ins_valid,
  input logic [TAG_W-1:0]  ins_tag,
  input logic [ADDR_W-1:0] ins_addr,
  input logic              snp_valid,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              chk_valid,
  input logic [TAG_W-1:0]  chk_tag,
  input logic              flush,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_reexec
);
  AST_RSP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rsp_hit && rsp_reexec) && ((rsp_hit || rsp_reexec) -> rsp_valid)); // R8

  AST_RSP_FOLLOWS_CHK: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> rsp_valid); // R2

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !rsp_valid); // R2

  AST_INSERT_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !flush && !(snp_valid && snp_addr == ins_addr))
    ##1 (chk_valid && chk_tag == $past(ins_tag)) |=> rsp_hit); // R2

  AST_SNOOP_BEATS_INSERT: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !flush && snp_valid && snp_addr == ins_addr)
    ##1 (chk_valid && chk_tag == $past(ins_tag)) |=> rsp_reexec); // R6

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush ##1 chk_valid |=> rsp_reexec); // R7
endmodule

bind sld_table sld_table_chk #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_sld_table.sv
`timescale 1ns/1ps
module tb_sld_table;
  localparam int N  = 8;
  localparam int TW = 6;
  localparam int AW = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ins_valid = 1'b0, snp_valid = 1'b0, chk_valid = 1'b0, flush = 1'b0;
  logic [TW-1:0] ins_tag = '0, chk_tag = '0;
  logic [AW-1:0] ins_addr = '0, snp_addr = '0;
  logic rsp_valid, rsp_hit, rsp_reexec;

  int checks = 0;
  int errors = 0;
  bit    exp_q[$];
  string req_q[$];

  logic          m_live [N];
  logic [TW-1:0] m_tag  [N];
  logic [AW-1:0] m_addr [N];
  int            m_ptr = 0;

  always #2.5 clk = ~clk;

  sld_table #(.ENTRIES(N), .TAG_W(TW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_tag(ins_tag),
    .ins_addr(ins_addr), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .chk_valid(chk_valid), .chk_tag(chk_tag), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_reexec(rsp_reexec)
  );

  // Monitor: pops one expectation per response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: response without check, actual valid=1 expected valid=0");
      end else begin
        bit e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (rsp_hit !== e || rsp_reexec !== !e) begin
          errors++;
          $display("FAIL %s: hit=%0b reexec=%0b expected hit=%0b reexec=%0b",
                   r, rsp_hit, rsp_reexec, e, !e);
        end
      end
    end
  end

  // Driver: one cycle of stimulus plus reference model update
  task automatic op(input bit iv, input int it, input logic [AW-1:0] ia,
                    input bit sv, input logic [AW-1:0] sa,
                    input bit cv, input int ct, input bit fl, input string req);
    int s;
    bit hit;
    ins_valid = iv; ins_tag = TW'(it); ins_addr = ia;
    snp_valid = sv; snp_addr = sa;
    chk_valid = cv; chk_tag = TW'(ct); flush = fl;
    if (cv) begin
      hit = 0;
      for (int i = 0; i < N; i++) if (m_live[i] && m_tag[i] == TW'(ct)) hit = 1;
      exp_q.push_back(hit);
      req_q.push_back(req);
    end
    if (fl) begin
      for (int i = 0; i < N; i++) m_live[i] = 0;
      m_ptr = 0;
    end else begin
      s = -1;
      if (iv) begin
        for (int i = 0; i < N; i++) if (s < 0 && m_live[i] && m_tag[i] == TW'(it)) s = i;
        for (int i = 0; i < N; i++) if (s < 0 && !m_live[i]) s = i;
        if (s < 0) begin
          s = m_ptr;
          m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
        end
      end
      if (sv) for (int i = 0; i < N; i++) if (m_live[i] && m_addr[i] == sa) m_live[i] = 0;
      if (iv) begin
        m_tag[s] = TW'(it); m_addr[s] = ia; m_live[s] = !(sv && sa == ia);
      end
    end
    @(posedge clk); #1;
  endtask

  task automatic ins(input int t, input logic [AW-1:0] a);
    op(1, t, a, 0, '0, 0, 0, 0, "");
  endtask
  task automatic snp(input logic [AW-1:0] a);
    op(0, 0, '0, 1, a, 0, 0, 0, "");
  endtask
  task automatic chk(input int t, input string req);
    op(0, 0, '0, 0, '0, 1, t, 0, req);
  endtask
  task automatic idle();
    op(0, 0, '0, 0, '0, 0, 0, 0, "");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_live[i] = 0; m_tag[i] = '0; m_addr[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_reexec !== 0) begin
      errors++;
      $display("FAIL R1: outputs %0b%0b%0b expected 000", rsp_valid, rsp_hit, rsp_reexec);
    end
    @(posedge clk); #1;
    chk(3, "R1");
    // R2 basic insert and check
    ins(3, 30'h100);
    chk(3, "R2");
    chk(4, "R2");
    // R3 single-bit-different store leaves entry, exact store kills it
    snp(30'h101);
    chk(3, "R3");
    snp(30'h2000_0100);
    chk(3, "R3");
    snp(30'h100);
    chk(3, "R3");
    // R3 one store kills two entries sharing an address
    ins(7, 30'h55); ins(8, 30'h55); ins(9, 30'h56);
    snp(30'h55);
    chk(7, "R3"); chk(8, "R3"); chk(9, "R3");
    // R4 re-insert replaces the address
    ins(5, 30'hB0); ins(5, 30'hC0);
    snp(30'hB0);
    chk(5, "R4");
    snp(30'hC0);
    chk(5, "R4");
    // R7 flush, and flush dropping a same-cycle insert
    op(1, 12, 30'h77, 0, '0, 0, 0, 1, "");
    chk(9, "R7"); chk(12, "R7");
    // R5 fill and evict in round-robin order
    for (int t = 10; t < 10 + N; t++) ins(t, AW'(30'h1000 + t));
    chk(10, "R5");
    ins(20, 30'h2020);
    chk(10, "R5"); chk(11, "R5"); chk(20, "R5");
    ins(21, 30'h2021);
    chk(11, "R5"); chk(12, "R5"); chk(21, "R5");
    // R6 same-cycle insert and snoop
    op(1, 30, 30'h3030, 1, 30'h3030, 0, 0, 0, "");
    chk(30, "R6");
    op(1, 31, 30'h3031, 1, 30'h3999, 0, 0, 0, "");
    chk(31, "R6");
    // R8 check sees state at start of cycle
    op(0, 0, '0, 1, 30'h3031, 1, 31, 0, "R8");
    chk(31, "R8");
    op(1, 40, 30'h4040, 0, '0, 1, 40, 0, "R8");
    chk(40, "R8");
    op(0, 0, '0, 0, '0, 1, 40, 1, "R8");
    chk(40, "R7");
    idle(); idle(); idle();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d responses missing, expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule